// File: doc/BRIEF.md
# Hot-Swap Power Sequencing Controller

This block is the clocked control core of a hot-pluggable add-in card. Comparator results for the host supplies and the card-side supplies reach it as synchronous logic levels. It also takes two active-low board-select inputs, a power-enable level from the host, a host reset input, a static strap that picks which host supplies count, and a kill input from the over-current block. From these it drives the enable for the external power switches and a status copy of that enable. It also drives an active-low health flag, an active-low signals-valid flag, and a complementary pair of local reset outputs for the card's back-end logic.

Power comes up in a fixed chain. The card must be fully seated, the host must enable it and the host supplies must be good. When all three hold, the switches turn on. The health flag follows once the card-side supplies reach their trip levels, and this also starts a reset-interval timer. The local resets and the signals-valid flag are released together, and only once the timer has expired and the host reset input is high. If the card-side supplies sag, the back end goes back into reset but the switches stay on. A host reset pulse must be longer than a deglitch window to be accepted, and it is then stretched to at least one full reset interval. The reset interval and the deglitch window are counted in clock cycles through parameters.

Top module: `hotswap_seq_ctrl`

## Requirements
- R1: While reset is held and right after it is released, gate_en_o is 0, drv_on_n_o is 1, health_n_o is 1, sig_valid_n_o is 1, lrst_n_o is 0 and lrst_o is 1.
- R2: gate_en_o rises at the clock edge that samples all of these together: both board-select inputs low, pwr_en_i high, oc_kill_i low and the host supplies good. It never rises otherwise.
- R3: With vsel_3v_only_i low, the host supplies are good only when host5_ok_i and host3_ok_i are both 1. With vsel_3v_only_i high, only host3_ok_i is used and host5_ok_i has no effect.
- R4: While the switches are on, the first edge that samples card5_ok_i and card3_ok_i both at 1 asserts health_n_o low and starts the reset-interval timer.
- R5: If host_rst_n_i is high, lrst_n_o and sig_valid_n_o are released at the edge that ends exactly RST_CYCLES cycles of health_n_o being low. Both are released in the same cycle.
- R6: Once the interval has expired, the release waits for host_rst_n_i to be high. It then happens at the first edge that samples it high.
- R7: At the edge after a host supply is sampled bad, gate_en_o is 0, sig_valid_n_o is 1 and lrst_n_o is 0.
- R8: At the edge after a card-side flag is sampled low with the switches on and all enabling conditions held, lrst_n_o is 0, health_n_o is 1 and sig_valid_n_o is 1, while gate_en_o stays 1.
- R9: A low on host_rst_n_i lasting GLITCH_CYCLES cycles or fewer is ignored. A low sampled on GLITCH_CYCLES+1 consecutive edges asserts the local reset at the last of those edges.
- R10: An accepted host reset keeps lrst_n_o low for at least RST_CYCLES cycles, and for as long as host_rst_n_i stays low.
- R11: At the edge after either board-select input is sampled high, pwr_en_i low, or oc_kill_i high, gate_en_o is 0, health_n_o is 1 and lrst_n_o is 0.
- R12: lrst_o is always the inverse of lrst_n_o.
- R13: drv_on_n_o is always the inverse of gate_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host5_ok_i | input | 1 | Host 5 V supply at or above trip |
| host3_ok_i | input | 1 | Host 3.3 V supply at or above trip |
| card5_ok_i | input | 1 | Card-side 5 V supply at or above trip |
| card3_ok_i | input | 1 | Card-side 3.3 V supply at or above trip |
| bdsel_a_n_i | input | 1 | Board-select A, active low |
| bdsel_b_n_i | input | 1 | Board-select B, active low |
| pwr_en_i | input | 1 | Host power enable, active high |
| host_rst_n_i | input | 1 | Host reset, active low |
| vsel_3v_only_i | input | 1 | Static strap: 1 = monitor only the 3.3 V host flag |
| oc_kill_i | input | 1 | Over-current kill from the breaker block |
| gate_en_o | output | 1 | Power switch gate enable |
| drv_on_n_o | output | 1 | Driver status, low while the gates are enabled |
| health_n_o | output | 1 | Card-side power healthy, active low |
| sig_valid_n_o | output | 1 | Card power valid and reset interval done, active low |
| lrst_n_o | output | 1 | Local back-end reset, active low |
| lrst_o | output | 1 | Local back-end reset, active high |

## Verification
Some relations are checked on every cycle. Any enabling condition that drops must remove the gates and assert the reset one edge later. A card-side sag with valid host conditions must keep the gates on. A gate turn-on must follow a full set of enabling conditions. Every release must come after a host-high sample and at least RST_CYCLES cycles of health held with the reset active. Other behaviours need the bench's scenarios: the exact release edge of the timer, the strap making the 5 V flag irrelevant, a host pulse at the deglitch width against one a cycle longer, and a host reset held well past the interval.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_RAMP   = 3'd1,
    ST_TIMING = 3'd2,
    ST_WAIT   = 3'd3,
    ST_RUN    = 3'd4
  } seq_state_e;
endpackage

// File: rtl/hs_host_rst_filter.sv
// Deglitches the host reset: a request is raised only when the input has
// been sampled low on more than GLITCH_CYCLES consecutive edges.
module hs_host_rst_filter #(
  parameter int unsigned GLITCH_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_rst_n_i,
  output logic reset_req_o
);
  localparam int unsigned FW = $clog2(GLITCH_CYCLES + 1);
  localparam logic [FW-1:0] LOW_MAX = FW'(GLITCH_CYCLES);

  logic [FW-1:0] low_cnt_q, low_cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en    = host_rst_n_i || (low_cnt_q != LOW_MAX);
    low_cnt_d = host_rst_n_i ? '0 : low_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_cnt_q <= '0;
    else if (cnt_en) low_cnt_q <= low_cnt_d;
  end

  assign reset_req_o = !host_rst_n_i && (low_cnt_q == LOW_MAX);
endmodule

// File: rtl/hs_reset_timer.sv
// Reset-interval counter: cleared by start, advances while run is high,
// done on the last cycle of an RST_CYCLES long interval.
module hs_reset_timer #(
  parameter int unsigned RST_CYCLES = 18_750_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(RST_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done_o = (cnt_q == LAST);

  always_comb begin
    cnt_en = start_i || (run_i && !done_o);
    cnt_d  = start_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
  import hs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok_i,
  input  logic       card_ok_i,
  input  logic       host_high_i,
  input  logic       host_req_i,
  input  logic       timer_done_i,
  output seq_state_e state_o,
  output logic       timer_start_o,
  output logic       timer_run_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!supply_ok_i) begin
      state_d = ST_OFF;
    end else begin
      case (state_q)
        ST_OFF:    state_d = ST_RAMP;
        ST_RAMP:   if (card_ok_i) state_d = ST_TIMING;
        ST_TIMING: begin
          if (!card_ok_i)        state_d = ST_RAMP;
          else if (timer_done_i) state_d = host_high_i ? ST_RUN : ST_WAIT;
        end
        ST_WAIT: begin
          if (!card_ok_i)       state_d = ST_RAMP;
          else if (host_high_i) state_d = ST_RUN;
        end
        ST_RUN: begin
          if (!card_ok_i)      state_d = ST_RAMP;
          else if (host_req_i) state_d = ST_TIMING;
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assign state_o       = state_q;
  assign timer_start_o = (state_d == ST_TIMING) && (state_q != ST_TIMING);
  assign timer_run_o   = (state_q == ST_TIMING);
endmodule

// File: rtl/hotswap_seq_ctrl.sv
module hotswap_seq_ctrl
  import hs_pkg::*;
#(
  parameter int unsigned RST_CYCLES    = 18_750_000,
  parameter int unsigned GLITCH_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host5_ok_i,
  input  logic host3_ok_i,
  input  logic card5_ok_i,
  input  logic card3_ok_i,
  input  logic bdsel_a_n_i,
  input  logic bdsel_b_n_i,
  input  logic pwr_en_i,
  input  logic host_rst_n_i,
  input  logic vsel_3v_only_i,
  input  logic oc_kill_i,
  output logic gate_en_o,
  output logic drv_on_n_o,
  output logic health_n_o,
  output logic sig_valid_n_o,
  output logic lrst_n_o,
  output logic lrst_o
);
  logic       host_good, seated_en, supply_ok, card_ok;
  logic       host_req, timer_start, timer_run, timer_done;
  seq_state_e state;

  always_comb begin
    host_good = vsel_3v_only_i ? host3_ok_i : (host3_ok_i && host5_ok_i);
    seated_en = !bdsel_a_n_i && !bdsel_b_n_i && pwr_en_i;
    supply_ok = host_good && seated_en && !oc_kill_i;
    card_ok   = card5_ok_i && card3_ok_i;
  end

  hs_host_rst_filter #(.GLITCH_CYCLES(GLITCH_CYCLES)) u_filt (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_rst_n_i (host_rst_n_i),
    .reset_req_o  (host_req)
  );

  hs_reset_timer #(.RST_CYCLES(RST_CYCLES)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (timer_start),
    .run_i   (timer_run),
    .done_o  (timer_done)
  );

  hs_seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_ok_i   (supply_ok),
    .card_ok_i     (card_ok),
    .host_high_i   (host_rst_n_i),
    .host_req_i    (host_req),
    .timer_done_i  (timer_done),
    .state_o       (state),
    .timer_start_o (timer_start),
    .timer_run_o   (timer_run)
  );

  always_comb begin
    gate_en_o     = (state != ST_OFF);
    drv_on_n_o    = (state == ST_OFF);
    health_n_o    = !((state == ST_TIMING) || (state == ST_WAIT) || (state == ST_RUN));
    sig_valid_n_o = (state != ST_RUN);
    lrst_n_o      = (state == ST_RUN);
    lrst_o        = (state != ST_RUN);
  end
endmodule

// File: rtl/hotswap_seq_chk.sv
module hotswap_seq_chk #(
  parameter int unsigned RST_CYCLES = 18_750_000
) (
  input logic clk,
  input logic rst_n,
  input logic host5_ok_i,
  input logic host3_ok_i,
  input logic card5_ok_i,
  input logic card3_ok_i,
  input logic bdsel_a_n_i,
  input logic bdsel_b_n_i,
  input logic pwr_en_i,
  input logic host_rst_n_i,
  input logic vsel_3v_only_i,
  input logic oc_kill_i,
  input logic gate_en_o,
  input logic health_n_o,
  input logic sig_valid_n_o,
  input logic lrst_n_o
);
  localparam int unsigned WW = $clog2(RST_CYCLES + 1);
  localparam logic [WW-1:0] WMAX = WW'(RST_CYCLES);

  logic          hosts_ok, enables_ok;
  logic [WW-1:0] win_q;

  assign hosts_ok   = vsel_3v_only_i ? host3_ok_i : (host3_ok_i && host5_ok_i);
  assign enables_ok = !bdsel_a_n_i && !bdsel_b_n_i && pwr_en_i && !oc_kill_i;

  // cycles with health asserted while the local reset is still held
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          win_q <= '0;
    else if (!health_n_o && !lrst_n_o) begin
      if (win_q != WMAX)                 win_q <= win_q + 1'b1;
    end else                             win_q <= '0;
  end

  assert_gate_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en_o) |-> $past(hosts_ok && enables_ok));

  assert_host_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !hosts_ok |=> (!gate_en_o && sig_valid_n_o && !lrst_n_o));

  assert_card_sag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en_o && hosts_ok && enables_ok && !(card5_ok_i && card3_ok_i))
      |=> (gate_en_o && health_n_o && sig_valid_n_o && !lrst_n_o));

  assert_release_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lrst_n_o) |-> (win_q >= WMAX));

  assert_release_host_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lrst_n_o) |-> $past(host_rst_n_i));

  assert_run_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lrst_n_o |-> (!health_n_o && gate_en_o));

  assert_unseat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bdsel_a_n_i || bdsel_b_n_i || !pwr_en_i || oc_kill_i)
      |=> (!gate_en_o && health_n_o && !lrst_n_o));
endmodule

bind hotswap_seq_ctrl hotswap_seq_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .host5_ok_i     (host5_ok_i),
  .host3_ok_i     (host3_ok_i),
  .card5_ok_i     (card5_ok_i),
  .card3_ok_i     (card3_ok_i),
  .bdsel_a_n_i    (bdsel_a_n_i),
  .bdsel_b_n_i    (bdsel_b_n_i),
  .pwr_en_i       (pwr_en_i),
  .host_rst_n_i   (host_rst_n_i),
  .vsel_3v_only_i (vsel_3v_only_i),
  .oc_kill_i      (oc_kill_i),
  .gate_en_o      (gate_en_o),
  .health_n_o     (health_n_o),
  .sig_valid_n_o  (sig_valid_n_o),
  .lrst_n_o       (lrst_n_o)
);

// File: tb/hotswap_seq_ctrl_tb.sv
module hotswap_seq_ctrl_tb;
  localparam int unsigned RST_CYC = 20;
  localparam int unsigned GLT_CYC = 5;

  logic clk, rst_n;
  logic host5_ok, host3_ok, card5_ok, card3_ok;
  logic bsa_n, bsb_n, pwr_en, host_rst_n, vsel, kill;
  logic gate_en, drv_on_n, health_n, sig_valid_n, lrst_n, lrst;

  int n_tests = 0;
  int n_fail  = 0;

  hotswap_seq_ctrl #(.RST_CYCLES(RST_CYC), .GLITCH_CYCLES(GLT_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .host5_ok_i(host5_ok), .host3_ok_i(host3_ok),
    .card5_ok_i(card5_ok), .card3_ok_i(card3_ok),
    .bdsel_a_n_i(bsa_n), .bdsel_b_n_i(bsb_n), .pwr_en_i(pwr_en),
    .host_rst_n_i(host_rst_n), .vsel_3v_only_i(vsel), .oc_kill_i(kill),
    .gate_en_o(gate_en), .drv_on_n_o(drv_on_n), .health_n_o(health_n),
    .sig_valid_n_o(sig_valid_n), .lrst_n_o(lrst_n), .lrst_o(lrst)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // stim bits: {bsa_n, bsb_n, pwr_en, host5, host3, card5, card3, host_rst_n, vsel, kill}
  // exp bits:  {gate_en, health_n, sig_valid_n, lrst_n}
  typedef struct packed {
    logic [9:0] stim;
    logic [7:0] hold;
    logic [3:0] exp;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{10'b1101100100, 8'd3,  4'b0110},  // R1 idle, unseated
    '{10'b0011100100, 8'd1,  4'b1110},  // R2 seated, enabled, hosts good
    '{10'b0011111100, 8'd1,  4'b1010},  // R4 card good -> health
    '{10'b0011111100, 8'd19, 4'b1010},  // R5 one cycle short of interval
    '{10'b0011111100, 8'd1,  4'b1001},  // R5 release with signals valid
    '{10'b0011110100, 8'd1,  4'b1110},  // R8 card 3V sag, gates stay on
    '{10'b0011111100, 8'd1,  4'b1010},  // R4 card back, timer restarted
    '{10'b0011111100, 8'd20, 4'b1001},  // R5 release after full interval
    '{10'b0010111100, 8'd1,  4'b0110},  // R7 R3 host 5V lost, strap low
    '{10'b0010111110, 8'd1,  4'b1110},  // R3 strap high: 5V flag ignored
    '{10'b0010111110, 8'd1,  4'b1010},  // R3 R4
    '{10'b0010111110, 8'd20, 4'b1001},  // R3 R5
    '{10'b0010011110, 8'd1,  4'b0110},  // R3 R7 host 3V lost, strap high
    '{10'b0011111100, 8'd1,  4'b1110},  // R2
    '{10'b0011111100, 8'd1,  4'b1010},  // R4
    '{10'b0011111100, 8'd20, 4'b1001},  // R5
    '{10'b0111111100, 8'd1,  4'b0110},  // R11 board-select B high
    '{10'b0011111100, 8'd22, 4'b1001},  // R2 R5 reseated
    '{10'b0011111101, 8'd1,  4'b0110},  // R11 over-current kill
    '{10'b0011111100, 8'd22, 4'b1001},  // R2 R5
    '{10'b0001111100, 8'd1,  4'b0110},  // R11 power enable low
    '{10'b0011111100, 8'd22, 4'b1001}   // R2 R5
  };

  task automatic apply(input logic [9:0] s);
    {bsa_n, bsb_n, pwr_en, host5_ok, host3_ok, card5_ok, card3_ok, host_rst_n, vsel, kill} = s;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // R12 and R13 are checked inside every call through the derived bits
  task automatic check(input string req, input logic [3:0] e);
    logic [5:0] got, exp6;
    got  = {gate_en, drv_on_n, health_n, sig_valid_n, lrst_n, lrst};
    exp6 = {e[3], ~e[3], e[2], e[1], e[0], ~e[0]};
    n_tests++;
    if (got !== exp6) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (gate,drv_n,health_n,sv_n,lrst_n,lrst)",
               req, got, exp6);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    apply(10'b1101100100);
    step(3);
    check("R1 R12 R13 during reset", 4'b0110);
    rst_n = 1'b1;
    step(1);
    check("R1 after reset", 4'b0110);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].stim);
      step(int'(VEC[i].hold));
      check($sformatf("table vector %0d", i), VEC[i].exp);
    end

    // R9: a low of exactly GLITCH cycles is rejected
    host_rst_n = 1'b0;
    step(GLT_CYC);
    check("R9 pulse at glitch width", 4'b1001);
    host_rst_n = 1'b1;
    step(1);
    check("R9 after short pulse", 4'b1001);

    // R9: one cycle longer is accepted at the last low edge
    host_rst_n = 1'b0;
    step(GLT_CYC + 1);
    check("R9 accepted pulse", 4'b1010);
    // R10: held well past the interval
    step(40);
    check("R10 held while host low", 4'b1010);
    host_rst_n = 1'b1;
    step(1);
    check("R10 R6 release on host high", 4'b1001);

    // R10: short accepted pulse still stretched to the interval
    host_rst_n = 1'b0;
    step(GLT_CYC + 1);
    host_rst_n = 1'b1;
    step(RST_CYC - 1);
    check("R10 minimum interval not yet over", 4'b1010);
    step(1);
    check("R10 release at interval end", 4'b1001);

    // R6: host reset low through initial power-up
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    apply(10'b0011111000);
    step(RST_CYC + 5);
    check("R6 interval over, host still low", 4'b1010);
    host_rst_n = 1'b1;
    step(1);
    check("R6 release on first host high", 4'b1001);

    finish_run();
  end
endmodule